// File: doc/BRIEF.md
# Pin-Triggered User RAM Clear Controller

This block holds a battery-backed user RAM of 242 bytes and can fill all of it with ones when an external clear pin is pulled low. The clear pin is asynchronous and active low. It passes through a two-stage synchroniser, and only its high-to-low transition counts. A clear starts on that transition only when the clear-enable bit in the control register is 1. The sweep then writes 8'hFF to one byte per clock, from address 0 up to the top user address.

When the last byte has been written, a completion flag is set. The block also latches an interrupt request if main power is reported present and the interrupt-enable bit is 1 at that moment. The active-low interrupt output combines this latched request with a single input that stands for every other interrupt source. Host software clears the flag, and with it the latched request, by writing 0 to the flag bit.

From the start of a clear, a lock output stays high for a fixed recovery time set by a parameter. This time is never shorter than the sweep. While the lock is high, host RAM reads return zero, and host RAM and control writes are dropped. Addresses above the user range belong to other storage. This block never writes them and reads them as zero.

Top module: `ramClearCtl`

## Requirements
- R1: A clear writes 8'hFF to every user byte at addresses 0 to 241, one byte per clock, and finishes 242 clocks after it starts.
- R2: A clear starts on the third rising clock edge after clrInN goes from 1 to 0, if control bit 0 (clear-enable) is 1 before that edge.
- R3: While clear-enable is 0, transitions on clrInN change neither the RAM contents nor the completion flag.
- R4: Addresses 242 to 255 lie outside the user RAM: host writes to them are dropped, reads return 8'h00, and a clear never writes them.
- R5: Control bit 2 (completion flag) becomes 1 on the same edge that writes the last byte. ctlRdata reads as {flag, interrupt-enable, clear-enable} in bits 2..0.
- R6: At completion, irqN goes low only if control bit 1 (interrupt-enable) is 1 and powerOk is 1. Otherwise it stays high.
- R7: A control write with bit 2 equal to 0 clears the flag and the latched interrupt. irqN then returns high unless otherIrq is 1. A write with bit 2 equal to 1 leaves the flag unchanged.
- R8: otherIrq at 1 drives irqN low whatever the flag state is.
- R9: hostLock is high for max(LOCK_CYCLES, 242) clocks from the start edge. While it is high, ramRdata reads 8'h00, and host RAM writes and control writes are ignored.
- R10: A falling edge on clrInN during an active sweep neither restarts the sweep nor extends the lock.
- R11: After reset, clear-enable, interrupt-enable, flag and hostLock are 0, and irqN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrInN | input | 1 | Asynchronous active-low clear request pin |
| powerOk | input | 1 | Main power present |
| otherIrq | input | 1 | OR of all other pending interrupt sources |
| ctlWe | input | 1 | Control register write strobe |
| ctlWdata | input | 3 | Control write data {flag, intEnable, clrEnable} |
| ctlRdata | output | 3 | Control read data {flag, intEnable, clrEnable} |
| ramWe | input | 1 | Host RAM write strobe |
| ramAddr | input | ADDR_W | Host RAM address |
| ramWdata | input | 8 | Host RAM write data |
| ramRdata | output | 8 | Host RAM read data (combinational) |
| hostLock | output | 1 | Recovery lockout active |
| irqN | output | 1 | Active-low interrupt |

## Verification
Some behaviour is checked by assertions on every cycle. Lock must cover the whole sweep, and reads must return zero under lock. A sweep must step until its last byte. A completed sweep must leave the flag set. With clear-enable low, no sweep may start, and with the flag and otherIrq both low, irqN must stay high.

Other behaviour can only be shown by the bench's scenarios, using its reference model. These scenarios cover the exact start latency through the synchroniser, the byte contents left behind, the out-of-range addresses, a second pin edge in mid-sweep, and the interrupt outcome with power absent or interrupts disabled.

// File: rtl/ramClearPkg.sv
package ramClearPkg;
  typedef struct packed {
    logic start;  // reset pointer, begin a sweep
    logic step;   // write one byte of ones and advance
  } sweepCmd_t;
endpackage

// File: rtl/ramClearCtrl.sv
module ramClearCtrl
  import ramClearPkg::*;
#(
  parameter int USER_BYTES  = 242,
  parameter int LOCK_CYCLES = 300
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      clrInN,
  input  logic      powerOk,
  input  logic      otherIrq,
  input  logic      ctlWe,
  input  logic [2:0] ctlWdata,
  input  logic      sweepLast,
  output sweepCmd_t cmd,
  output logic      busy,
  output logic      hostLock,
  output logic      irqN,
  output logic [2:0] ctlRdata
);
  localparam int LOCK_LEN = (LOCK_CYCLES > USER_BYTES) ? LOCK_CYCLES : USER_BYTES;
  localparam int LCNT_W   = $clog2(LOCK_LEN + 1);

  // syncQ[0], syncQ[1]: synchroniser; syncQ[2]: previous synced value
  logic [2:0]        syncQ;
  logic              clrFall;
  logic              enBit, ieBit, flagBit, intPend;
  logic [LCNT_W-1:0] lockCnt;

  assign clrFall   = syncQ[2] & ~syncQ[1];
  assign hostLock  = (lockCnt != '0);
  assign cmd.start = clrFall & enBit & ~busy;
  assign cmd.step  = busy;
  assign irqN      = ~(intPend | otherIrq);
  assign ctlRdata  = {flagBit, ieBit, enBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 3'b111;
    else       syncQ <= {syncQ[1], syncQ[0], clrInN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit   <= 1'b0;
      ieBit   <= 1'b0;
      flagBit <= 1'b0;
      intPend <= 1'b0;
      busy    <= 1'b0;
      lockCnt <= '0;
    end else begin
      if (ctlWe && !hostLock) begin
        enBit <= ctlWdata[0];
        ieBit <= ctlWdata[1];
        if (!ctlWdata[2]) begin
          flagBit <= 1'b0;
          intPend <= 1'b0;
        end
      end
      if (cmd.start) begin
        busy    <= 1'b1;
        lockCnt <= LCNT_W'(LOCK_LEN);
      end else begin
        if (hostLock) lockCnt <= lockCnt - 1'b1;
        if (busy && sweepLast) begin
          busy    <= 1'b0;
          flagBit <= 1'b1;
          if (ieBit && powerOk) intPend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ramClearData.sv
module ramClearData
  import ramClearPkg::*;
#(
  parameter int USER_BYTES = 242,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  sweepCmd_t         cmd,
  input  logic              hostLock,
  input  logic              ramWe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [7:0]        ramWdata,
  output logic [7:0]        ramRdata,
  output logic              sweepLast
);
  localparam int PTR_W = $clog2(USER_BYTES);

  logic [7:0]       mem [USER_BYTES];
  logic [PTR_W-1:0] ptr;
  logic             inRange;

  assign inRange   = (ramAddr < ADDR_W'(USER_BYTES));
  assign sweepLast = (ptr == PTR_W'(USER_BYTES - 1));
  assign ramRdata  = (!hostLock && inRange) ? mem[ramAddr[PTR_W-1:0]] : 8'h00;

  // battery-backed storage: no reset on contents
  always_ff @(posedge clk) begin
    if (cmd.start) begin
      ptr <= '0;
    end else if (cmd.step) begin
      mem[ptr] <= 8'hFF;
      ptr      <= ptr + 1'b1;
    end
    if (ramWe && !hostLock && inRange) mem[ramAddr[PTR_W-1:0]] <= ramWdata;
  end
endmodule

// File: rtl/ramClearCtl.sv
module ramClearCtl
  import ramClearPkg::*;
#(
  parameter int USER_BYTES  = 242,
  parameter int LOCK_CYCLES = 300,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrInN,
  input  logic              powerOk,
  input  logic              otherIrq,
  input  logic              ctlWe,
  input  logic [2:0]        ctlWdata,
  output logic [2:0]        ctlRdata,
  input  logic              ramWe,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [7:0]        ramWdata,
  output logic [7:0]        ramRdata,
  output logic              hostLock,
  output logic              irqN
);
  sweepCmd_t cmd;
  logic      sweepBusy;
  logic      sweepLast;

  ramClearCtrl #(.USER_BYTES(USER_BYTES), .LOCK_CYCLES(LOCK_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .clrInN(clrInN), .powerOk(powerOk),
    .otherIrq(otherIrq), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .sweepLast(sweepLast), .cmd(cmd), .busy(sweepBusy),
    .hostLock(hostLock), .irqN(irqN), .ctlRdata(ctlRdata)
  );

  ramClearData #(.USER_BYTES(USER_BYTES), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .cmd(cmd), .hostLock(hostLock), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .sweepLast(sweepLast)
  );
endmodule

// File: rtl/ramClearChk.sv
module ramClearChk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       sweepLast,
  input logic       hostLock,
  input logic       irqN,
  input logic       otherIrq,
  input logic [2:0] ctlRdata,
  input logic [7:0] ramRdata
);
  // R9: sweep always runs under lock
  assert_busy_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> hostLock);
  // R9: reads return zero under lock
  assert_read_blocked_R9: assert property (@(posedge clk) disable iff (!rstN)
    hostLock |-> ramRdata == 8'h00);
  // R1: sweep keeps stepping until the last byte
  assert_sweep_continues_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sweepLast) |=> busy);
  // R5: last byte ends the sweep and sets the flag
  assert_done_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sweepLast) |=> (!busy && ctlRdata[2]));
  // R3: no start while clear-enable is low
  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlRdata[0] && !busy) |=> !busy);
  // R7: no flag and no other source means interrupt inactive
  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlRdata[2] && !otherIrq) |-> irqN);
  // R8: another source always pulls the line
  assert_other_irq_R8: assert property (@(posedge clk) disable iff (!rstN)
    otherIrq |-> !irqN);
endmodule

bind ramClearCtl ramClearChk uChk (
  .clk(clk), .rstN(rstN), .busy(sweepBusy), .sweepLast(sweepLast),
  .hostLock(hostLock), .irqN(irqN), .otherIrq(otherIrq),
  .ctlRdata(ctlRdata), .ramRdata(ramRdata)
);

// File: tb/sim_ramClearCtl.sv
`timescale 1ns/1ps
module sim_ramClearCtl;
  localparam int USER = 242;
  localparam int LOCK = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clrInN = 1'b1, powerOk = 1'b1, otherIrq = 1'b0;
  logic       ctlWe = 1'b0, ramWe = 1'b0;
  logic [2:0] ctlWdata = 3'b000;
  logic [7:0] ramAddr = 8'h00, ramWdata = 8'h00;
  logic [2:0] ctlRdata;
  logic [7:0] ramRdata;
  logic       hostLock, irqN;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ramClearCtl u0 (
    .clk(clk), .rstN(rstN), .clrInN(clrInN), .powerOk(powerOk),
    .otherIrq(otherIrq), .ctlWe(ctlWe), .ctlWdata(ctlWdata),
    .ctlRdata(ctlRdata), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata), .hostLock(hostLock),
    .irqN(irqN)
  );

  // ---------------- behavioural reference ----------------
  bit pinHist[$];          // newest sample at front
  int mMem [256];
  bit mKnown [256];
  bit mEn, mIe, mFlag, mInt, mBusy;
  int mPtr, mLock;
  bit mFall, mLocked, mStart, mOldIe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinHist = '{1, 1, 1};
      mEn = 0; mIe = 0; mFlag = 0; mInt = 0; mBusy = 0; mPtr = 0; mLock = 0;
    end else begin
      mFall   = pinHist[2] && !pinHist[1];
      mLocked = (mLock > 0);
      mStart  = mFall && mEn && !mBusy;
      mOldIe  = mIe;
      if (mBusy) begin
        mMem[mPtr] = 255; mKnown[mPtr] = 1;
        if (mPtr == USER - 1) begin
          mBusy = 0; mFlag = 1;
          if (mOldIe && powerOk) mInt = 1;
        end else mPtr++;
      end
      if (ramWe && !mLocked && ramAddr < USER) begin
        mMem[ramAddr] = ramWdata; mKnown[ramAddr] = 1;
      end
      if (ctlWe && !mLocked) begin
        mEn = ctlWdata[0]; mIe = ctlWdata[1];
        if (!ctlWdata[2]) begin mFlag = 0; mInt = 0; end
      end
      if (mStart) begin mBusy = 1; mPtr = 0; mLock = (LOCK > USER) ? LOCK : USER; end
      else if (mLock > 0) mLock--;
      pinHist.push_front(clrInN);
      void'(pinHist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(hostLock == (mLock > 0), "R9 lock", hostLock, mLock > 0);
      chk(irqN == !(mInt || otherIrq), "R6 irq", irqN, !(mInt || otherIrq));
      chk(ctlRdata == {mFlag, mIe, mEn}, "R5 ctl", ctlRdata, {mFlag, mIe, mEn});
      if (mLock > 0 || ramAddr >= USER)
        chk(ramRdata == 8'h00, "R4 R9 ram zero", ramRdata, 0);
      else if (mKnown[ramAddr])
        chk(ramRdata == mMem[ramAddr][7:0], "R1 ram", ramRdata, mMem[ramAddr]);
    end
  end

  task automatic drv(); @(negedge clk); #1; endtask
  task automatic waitN(input int n); repeat (n) drv(); endtask
  task automatic ctlWrite(input logic [2:0] d);
    drv(); ctlWe = 1; ctlWdata = d; drv(); ctlWe = 0;
  endtask
  task automatic ramWrite(input logic [7:0] a, input logic [7:0] d);
    drv(); ramWe = 1; ramAddr = a; ramWdata = d; drv(); ramWe = 0;
  endtask
  task automatic pinPulse();
    drv(); clrInN = 0; waitN(4); clrInN = 1;
  endtask

  initial begin
    waitN(3); rstN = 1; drv();
    // R11 reset state
    chk(ctlRdata == 3'b000 && !hostLock && irqN, "R11 reset", {ctlRdata, hostLock, irqN}, 5'b00001);

    // preload bytes, including out-of-range address (R4)
    ramWrite(8'd0, 8'h12); ramWrite(8'd100, 8'h34); ramWrite(8'd241, 8'h56);
    ramWrite(8'd245, 8'h78);
    drv(); ramAddr = 8'd245; drv();
    chk(ramRdata == 8'h00, "R4 out of range read", ramRdata, 0);

    // R3: disabled clear pin does nothing
    pinPulse(); waitN(10);
    ramAddr = 8'd100; drv();
    chk(ramRdata == 8'h34 && ctlRdata[2] == 0 && !hostLock, "R3 disabled",
        {ramRdata, ctlRdata[2]}, {8'h34, 1'b0});

    // R2: enabled clear, interrupts on, power present
    ctlWrite(3'b011);
    drv(); clrInN = 0;
    drv(); drv();
    chk(!hostLock, "R2 not yet started", hostLock, 0);
    drv();
    chk(hostLock, "R2 lock after third edge", hostLock, 1);
    // R9: attempted writes under lock
    ramWe = 1; ramAddr = 8'd5; ramWdata = 8'h11; ctlWe = 1; ctlWdata = 3'b000;
    drv(); ramWe = 0; ctlWe = 0;
    // R10: second falling edge mid-sweep
    waitN(40); clrInN = 1; waitN(6); clrInN = 0; waitN(6); clrInN = 1;
    waitN(LOCK);
    chk(!hostLock && ctlRdata == 3'b111 && !irqN, "R10 R6 after clear",
        {hostLock, ctlRdata, irqN}, 5'b01110);
    // R1: every user byte now ones
    for (int a = 0; a < USER; a++) begin ramAddr = 8'(a); drv(); end
    ramAddr = 8'd5; drv();
    chk(ramRdata == 8'hFF, "R9 locked write dropped", ramRdata, 8'hFF);
    ramAddr = 8'd245; drv();
    chk(ramRdata == 8'h00, "R4 untouched by clear", ramRdata, 0);

    // R7: writing 1 to flag keeps it, writing 0 clears it
    ctlWrite(3'b111); drv();
    chk(ctlRdata[2] && !irqN, "R7 write one keeps flag", ctlRdata[2], 1);
    ctlWrite(3'b011); drv();
    chk(!ctlRdata[2] && irqN, "R7 flag cleared", {ctlRdata[2], irqN}, 2'b01);

    // R8: other source
    otherIrq = 1; drv();
    chk(!irqN, "R8 other source", irqN, 0);
    otherIrq = 0; drv();

    // R6: power absent at completion
    ramWrite(8'd7, 8'h00);
    powerOk = 0; pinPulse(); waitN(LOCK + 10);
    chk(ctlRdata[2] && irqN, "R6 no power no irq", {ctlRdata[2], irqN}, 2'b11);
    powerOk = 1;
    // R6: interrupt disabled
    ctlWrite(3'b001); pinPulse(); waitN(LOCK + 10);
    chk(ctlRdata[2] && irqN, "R6 ie off no irq", {ctlRdata[2], irqN}, 2'b11);
    ramAddr = 8'd7; drv();
    chk(ramRdata == 8'hFF, "R1 refilled", ramRdata, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule